// File: doc/BRIEF.md
# Clock-Chain Reset Release Sequencer

This block releases the resets of a clock chain in a fixed one-way order: the reference clock first, then the PLL, then the derived local-oscillator branches. The PLL reset follows the reference supply good flag. The branch resets stay asserted until three conditions hold together: the reference supply is good, the PLL supply is good, and the PLL reports lock. That combined condition must then remain true for a minimum hold time, so that brief wobble after power-up is masked. After the hold, the branches come out of reset one at a time. Each branch has its own fixed offset, counted in clock cycles from the end of the hold. These micro-staggered releases avoid a current burst, and their timing repeats exactly from one sequence to the next.

If the combined condition drops at any point during the stagger or in normal running, every branch re-enters reset on the same edge. The sequence then starts again and needs a full hold. A power-fail input puts the block in a degraded mode. In that mode the reference path stays alive, so the PLL reset is not touched, while all derived branches are held in reset. A sticky diagnostic tag records the event. Leaving the degraded mode requires the supplies to recover, lock to be confirmed again, and a full hold followed by a fresh stagger. The tag clears only when that sequence completes.

Top module: `clk_chain_rst_seq`

## Requirements
- R1: No branch reset is released unless `ref_good`, `pll_good` and `pll_locked` are all high and `power_fail` is low. Any other combination holds every bit of `branch_rst_n` at 0 indefinitely.
- R2: `pll_rst_n` equals `ref_good` as sampled on the previous clock edge, and `power_fail` has no effect on it. Whenever any branch is released, `pll_rst_n` is 1.
- R3: The combined good condition is sampled high on an edge while the block waits. Counting that edge as edge 1, the hold ends at edge `HOLD_CYC`+1. If the condition is low on any edge during the hold, the count restarts from the next edge on which the condition is high.
- R4: Branch i (bit i of `branch_rst_n`) is released (goes to 1) at edge `HOLD_CYC`+1+OFF[i], where OFF[i] is the field `BR_OFFSET[i*CNT_W +: CNT_W]`. Once released, it stays released while the condition holds.
- R5: If the combined good condition is low on an edge during the stagger or while running, all branches are 0 after that edge. A new release then needs a full hold and a full stagger.
- R6: `power_fail` sampled high on an edge has these effects after that edge: all branches are 0, `seq_state` is 5, and `pf_tag` is 1. `pll_rst_n` keeps following `ref_good`.
- R7: After `power_fail` falls, the block returns to waiting and releases nothing until the combined good condition and a full hold occur again. `pf_tag` stays 1 until every branch has been released, and then clears.
- R8: `seq_state` reports the phase with these codes: 0 = idle, 1 = waiting for good, 2 = hold, 3 = stagger, 4 = running, 5 = degraded.
- R9: While `rst_n` is low, `branch_rst_n` is 0, `pll_rst_n` is 0, `seq_state` is 0 and `pf_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_good | input | 1 | Reference clock supply is currently good |
| pll_good | input | 1 | PLL supply is currently good |
| pll_locked | input | 1 | PLL lock confirmation |
| power_fail | input | 1 | Power-fail warning; selects the degraded mode |
| pll_rst_n | output | 1 | PLL reset, active low, follows the reference good flag |
| branch_rst_n | output | N_BR | Per-branch derived-clock resets, active low |
| seq_state | output | 3 | Sequencer phase code |
| pf_tag | output | 1 | Sticky power-fail diagnostic tag |

## Verification
The bench sweeps every input combination that is not fully good, including every combination with power-fail set, and checks that none of them releases a branch. It then breaks the good condition on every single cycle of the hold and of the stagger. A design that kept its hold count across such a break, or released a branch late or early, shows up as a branch release on the wrong edge. A design that dropped branches one at a time after a fault would also be caught. The bench triggers power-fail in the hold, the stagger and the running phase. A design that cut the PLL reset, cleared the tag too early, or resumed without a full hold would fail those checks.

// File: rtl/clk_chain_rst_seq.sv
module clk_chain_rst_seq #(
  parameter int N_BR     = 4,
  parameter int CNT_W    = 18,
  parameter int HOLD_CYC = 125000,
  parameter logic [N_BR*CNT_W-1:0] BR_OFFSET = {18'd62500, 18'd50000, 18'd25000, 18'd0}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_good,
  input  logic            pll_good,
  input  logic            pll_locked,
  input  logic            power_fail,
  output logic            pll_rst_n,
  output logic [N_BR-1:0] branch_rst_n,
  output logic [2:0]      seq_state,
  output logic            pf_tag
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_WAIT = 3'd1, S_HOLD = 3'd2,
    S_STAG = 3'd3, S_RUN  = 3'd4, S_DEG  = 3'd5
  } st_t;

  function automatic logic [CNT_W-1:0] f_max_off();
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_BR; i++)
      if (BR_OFFSET[i*CNT_W +: CNT_W] > m) m = BR_OFFSET[i*CNT_W +: CNT_W];
    return m;
  endfunction

  localparam logic [CNT_W-1:0] MAX_OFF   = f_max_off();
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  st_t              st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             all_good;

  assign all_good = ref_good & pll_good & pll_locked;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (power_fail && st != S_IDLE) begin
      st_n  = S_DEG;
      cnt_n = '0;
    end else begin
      case (st)
        S_IDLE: st_n = S_WAIT;
        S_WAIT: begin
          cnt_n = '0;
          if (all_good) st_n = S_HOLD;
        end
        S_HOLD: begin
          if (!all_good) begin
            st_n  = S_WAIT;
            cnt_n = '0;
          end else if (cnt == HOLD_LAST) begin
            st_n  = S_STAG;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_STAG: begin
          if (!all_good) begin
            st_n  = S_WAIT;
            cnt_n = '0;
          end else if (cnt == MAX_OFF) begin
            st_n = S_RUN;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_RUN: begin
          if (!all_good) begin
            st_n  = S_WAIT;
            cnt_n = '0;
          end
        end
        default: begin
          st_n  = S_WAIT;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      pll_rst_n <= 1'b0;
      pf_tag    <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      pll_rst_n <= ref_good;
      if (st_n == S_DEG)      pf_tag <= 1'b1;
      else if (st_n == S_RUN) pf_tag <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_BR; g++) begin : g_br
    assign branch_rst_n[g] = (st == S_RUN) |
                             ((st == S_STAG) && (cnt >= BR_OFFSET[g*CNT_W +: CNT_W]));
  end

  assign seq_state = st;

  a_r1_release_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    (|branch_rst_n) |-> ($past(all_good) && !$past(power_fail)));

  a_r2_pll_before_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (|branch_rst_n) |-> pll_rst_n);

  a_r5_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(branch_rst_n) & ~branch_rst_n) != '0) |-> (branch_rst_n == '0));

  a_r6_fail_holds_branches: assert property (@(posedge clk) disable iff (!rst_n)
    power_fail |=> (branch_rst_n == '0));

  a_r6_tag_in_degraded: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEG) |-> pf_tag);

endmodule

// File: tb/clk_chain_rst_seq_bench.sv
`timescale 1ns/1ps
module clk_chain_rst_seq_bench;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int H  = 5;
  localparam int OFF [N] = '{0, 2, 4, 5};
  localparam int MX = 5;
  localparam int WIN = H + MX + 4;

  logic clk = 0, rst_n = 0;
  logic ref_good = 0, pll_good = 0, pll_locked = 0, power_fail = 0;
  logic pll_rst_n, pf_tag;
  logic [N-1:0] branch_rst_n;
  logic [2:0] seq_state;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  clk_chain_rst_seq #(.N_BR(N), .CNT_W(CW), .HOLD_CYC(H),
    .BR_OFFSET({8'd5, 8'd4, 8'd2, 8'd0})) u_clk_chain_rst_seq (
    .clk(clk), .rst_n(rst_n), .ref_good(ref_good), .pll_good(pll_good),
    .pll_locked(pll_locked), .power_fail(power_fail), .pll_rst_n(pll_rst_n),
    .branch_rst_n(branch_rst_n), .seq_state(seq_state), .pf_tag(pf_tag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic drive(input logic r, input logic p, input logic l, input logic f);
    ref_good = r; pll_good = p; pll_locked = l; power_fail = f;
  endtask

  task automatic measure(input string req);
    int first [N];
    int st1, sth;
    for (int i = 0; i < N; i++) first[i] = -1;
    st1 = -1; sth = -1;
    for (int c = 1; c <= WIN; c++) begin
      step(1);
      if (c == 1) st1 = seq_state;
      if (c == H + 1) sth = seq_state;
      for (int i = 0; i < N; i++)
        if (first[i] < 0 && branch_rst_n[i]) first[i] = c;
    end
    for (int i = 0; i < N; i++)
      chk(first[i] == H + 1 + OFF[i], req, first[i], H + 1 + OFF[i]);
    chk(st1 == 2, "R8 hold code", st1, 2);
    chk(sth == 3, "R8 stagger code", sth, 3);
    chk(seq_state == 4, "R8 run code", seq_state, 4);
    chk(branch_rst_n == '1, "R4 all released", branch_rst_n, 15);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(2);
    // R9 reset state
    chk(branch_rst_n == 0, "R9 branches", branch_rst_n, 0);
    chk(pll_rst_n == 0, "R9 pll reset", pll_rst_n, 0);
    chk(seq_state == 0, "R9 state", seq_state, 0);
    chk(pf_tag == 0, "R9 tag", pf_tag, 0);
    rst_n = 1;
    step(2);
    chk(seq_state == 1, "R8 wait code", seq_state, 1);

    // R2 pll reset follows ref_good one edge later
    drive(1, 0, 0, 0);
    chk(pll_rst_n == 0, "R2 before edge", pll_rst_n, 0);
    step(1);
    chk(pll_rst_n == 1, "R2 after edge", pll_rst_n, 1);

    // R1 sweep of every non-releasing combination
    for (int m = 0; m < 16; m++) begin
      bit seen;
      if (m == 7) continue;
      drive(m[0], m[1], m[2], m[3]);
      seen = 0;
      for (int c = 0; c < WIN; c++) begin
        step(1);
        if (branch_rst_n != 0) seen = 1;
        if (pll_rst_n != m[0]) seen = 1;
      end
      chk(!seen, "R1 no release / R2 pll follows", m, 0);
      drive(0, 0, 0, 0);
      step(2);
    end

    // R3 R4 clean sequence, tag stays clear
    drive(1, 1, 1, 0);
    measure("R4 branch release edge");
    chk(pf_tag == 0, "R7 tag clear", pf_tag, 0);

    // R5 drop during run
    pll_locked = 0;
    step(1);
    chk(branch_rst_n == 0, "R5 run drop", branch_rst_n, 0);
    chk(seq_state == 1, "R5 back to wait", seq_state, 1);
    pll_locked = 1;
    measure("R5 full restart");

    // R3 break on each hold cycle
    for (int k = 0; k < H; k++) begin
      pll_good = 0; step(1);
      drive(1, 1, 1, 0);
      step(k + 1);
      pll_good = 0; step(1);
      chk(branch_rst_n == 0, "R3 held in break", branch_rst_n, 0);
      pll_good = 1;
      measure("R3 hold restart");
    end

    // R5 break on each stagger cycle
    for (int k = 0; k <= MX; k++) begin
      ref_good = 0; step(1);
      ref_good = 1;
      step(H + 1 + k);
      ref_good = 0; step(1);
      chk(branch_rst_n == 0, "R5 stagger drop", branch_rst_n, 0);
      ref_good = 1;
      measure("R5 stagger restart");
    end

    // R6 R7 power fail in hold, stagger, run
    for (int p = 0; p < 3; p++) begin
      pll_locked = 0; step(1);
      pll_locked = 1;
      if (p == 0) step(3);
      else if (p == 1) step(H + 2);
      else step(WIN);
      power_fail = 1;
      step(1);
      chk(branch_rst_n == 0, "R6 branches held", branch_rst_n, 0);
      chk(seq_state == 5, "R6 degraded code", seq_state, 5);
      chk(pf_tag == 1, "R6 tag set", pf_tag, 1);
      chk(pll_rst_n == 1, "R6 pll kept", pll_rst_n, 1);
      pll_good = 0; pll_locked = 0;
      step(3);
      chk(pll_rst_n == 1 && branch_rst_n == 0, "R6 dip held", branch_rst_n, 0);
      power_fail = 0; pll_good = 1;
      step(1);
      chk(seq_state == 1, "R7 back to wait", seq_state, 1);
      chk(pf_tag == 1, "R7 tag sticky", pf_tag, 1);
      if (p == 2) begin
        bit seen;
        seen = 0;
        for (int c = 0; c < WIN; c++) begin
          step(1);
          if (branch_rst_n != 0) seen = 1;
        end
        chk(!seen, "R7 needs relock", branch_rst_n, 0);
        chk(pf_tag == 1, "R7 tag until release", pf_tag, 1);
      end
      pll_locked = 1;
      measure("R7 recover release");
      chk(pf_tag == 0, "R7 tag cleared", pf_tag, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule